// File: doc/BRIEF.md
# Register File with Shadow Checkpoint

This block is a core's integer register file with a full shadow copy beside it and a saved program counter. Software brackets a speculative region with three requests: begin, commit and rollback. A begin request stalls the pipeline. The block then copies the live registers into the shadow copy, one register per cycle, and saves the current PC. It raises a done pulse, and only after that does it release the stall.

A commit throws the checkpoint away and leaves the live registers as they are. A rollback puts every live register back to its checkpointed value in a single cycle. It also presents the saved PC with a one-cycle valid pulse, so the fetch stage can be redirected. The core reaches the live registers through two combinational read ports and one write port. A commit or rollback that arrives with no complete checkpoint does nothing except raise an error pulse.

Top module: `regfile_ckpt`

## Requirements
- R1: A write with `wr_en` high while `stall` is low updates `wr_addr` at the clock edge. Both read ports return the stored value combinationally for any address.
- R2: A begin request accepted while `stall` is low drives `stall` high from the next cycle. After the edge that accepts the begin, `ckpt_done` is high for exactly one cycle, NREG cycles later, with `stall` still high and `ckpt_valid` high. `stall` falls in the cycle that follows.
- R3: Writes presented while `stall` is high are dropped, both during the copy and in the done cycle.
- R4: A commit with a valid checkpoint clears `ckpt_valid` in the next cycle. It leaves every register unchanged and produces no restore pulse.
- R5: A rollback with a valid checkpoint makes every register read, from the next cycle on, the value it held at the edge that accepted the begin. It also clears `ckpt_valid`.
- R6: After an accepted rollback, `restore_valid` is high for exactly one cycle. In that cycle `restore_pc` equals the `pc_in` value sampled with the accepted begin.
- R7: A commit or rollback while `ckpt_valid` is low changes no register and no checkpoint state, and `err` is high for the following cycle. This includes a request made during the copy. `err` is low otherwise.
- R8: A begin request while `stall` is high is ignored, and no second copy starts. A begin accepted while a checkpoint is valid discards that checkpoint and takes a new one.
- R9: Requests made in the same cycle are handled in a fixed priority order: rollback before commit, then commit before begin. A begin is dropped whenever commit or rollback is also requested. A write in the same cycle as an accepted rollback is dropped.
- R10: After reset, `stall`, `ckpt_done`, `ckpt_valid`, `restore_valid` and `err` are low, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_addr | input | AW | Read port A address |
| rd_a_data | output | DW | Read port A data |
| rd_b_addr | input | AW | Read port B address |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| pc_in | input | PCW | PC saved when a begin request is accepted |
| begin_req | input | 1 | Request to take a checkpoint |
| commit_req | input | 1 | Request to discard the checkpoint |
| rollback_req | input | 1 | Request to restore from the checkpoint |
| stall | output | 1 | Holds the pipeline while a checkpoint is taken |
| ckpt_done | output | 1 | One-cycle pulse when the copy completes |
| ckpt_valid | output | 1 | A complete checkpoint is held |
| restore_valid | output | 1 | One-cycle pulse that qualifies restore_pc |
| restore_pc | output | PCW | PC to redirect to after a rollback |
| err | output | 1 | Pulse for a commit or rollback with no checkpoint |

## Verification
The bench builds the block with NREG=8, DW=16 and PCW=16. With only eight registers, every register can be written, read on both ports and compared after each checkpoint, commit and rollback. The copy window is short enough that a write is attempted in every cycle of it. The small PC and data widths let each pass use its own arithmetic pattern, so a register restored from the wrong generation or the wrong slot shows up as a mismatch.

// File: rtl/regfile_ckpt.sv
module regfile_ckpt #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int PCW  = 32,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  rd_a_addr,
  output logic [DW-1:0]  rd_a_data,
  input  logic [AW-1:0]  rd_b_addr,
  output logic [DW-1:0]  rd_b_data,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [PCW-1:0] pc_in,
  input  logic           begin_req,
  input  logic           commit_req,
  input  logic           rollback_req,
  output logic           stall,
  output logic           ckpt_done,
  output logic           ckpt_valid,
  output logic           restore_valid,
  output logic [PCW-1:0] restore_pc,
  output logic           err
);

  logic [DW-1:0]  regs   [NREG];
  logic [DW-1:0]  shadow [NREG];
  logic [PCW-1:0] shadow_pc;
  logic [AW-1:0]  idx;
  logic           busy;

  wire end_req = commit_req | rollback_req;
  wire do_rb   = rollback_req & ckpt_valid;
  wire do_cm   = commit_req & ~rollback_req & ckpt_valid;
  wire do_bg   = begin_req & ~end_req & ~stall;
  wire wr_ok   = wr_en & ~stall & ~do_rb;

  assign stall     = busy | ckpt_done;
  assign rd_a_data = regs[rd_a_addr];
  assign rd_b_data = regs[rd_b_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      idx           <= '0;
      ckpt_done     <= 1'b0;
      ckpt_valid    <= 1'b0;
      restore_valid <= 1'b0;
      restore_pc    <= '0;
      shadow_pc     <= '0;
      err           <= 1'b0;
    end else begin
      ckpt_done     <= 1'b0;
      restore_valid <= 1'b0;
      err           <= end_req & ~ckpt_valid;
      if (do_bg) begin
        busy       <= 1'b1;
        idx        <= '0;
        ckpt_valid <= 1'b0;
        shadow_pc  <= pc_in;
      end else if (busy) begin
        idx <= idx + 1'b1;
        if (idx == AW'(NREG - 1)) begin
          busy       <= 1'b0;
          ckpt_done  <= 1'b1;
          ckpt_valid <= 1'b1;
        end
      end
      if (do_rb | do_cm) ckpt_valid <= 1'b0;
      if (do_rb) begin
        restore_valid <= 1'b1;
        restore_pc    <= shadow_pc;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n) begin
        regs[i]   <= '0;
        shadow[i] <= '0;
      end else begin
        if (do_rb)
          regs[i] <= shadow[i];
        else if (wr_ok && wr_addr == AW'(i))
          regs[i] <= wr_data;
        if (busy && idx == AW'(i))
          shadow[i] <= regs[i];
      end
    end
  end

endmodule

// File: rtl/regfile_ckpt_chk.sv
module regfile_ckpt_chk #(
  parameter int NREG = 32
) (
  input logic clk,
  input logic rst_n,
  input logic begin_req,
  input logic commit_req,
  input logic rollback_req,
  input logic stall,
  input logic ckpt_done,
  input logic ckpt_valid,
  input logic restore_valid,
  input logic err
);
  localparam int CW = $clog2(NREG + 2) + 1;
  logic [CW-1:0] win;

  always_ff @(posedge clk) begin
    if (!rst_n)     win <= '0;
    else if (stall) win <= win + 1'b1;
    else            win <= '0;
  end

  p_done_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_done |-> (win == CW'(NREG)));
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_done |=> (!ckpt_done && !stall));
  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> $past(ckpt_done));
  p_valid_on_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_done |-> (ckpt_valid && stall));
  p_begin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_req && !stall && !commit_req && !rollback_req) |=> (stall && !ckpt_valid));
  p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && !rollback_req && ckpt_valid) |=> (!ckpt_valid && !restore_valid && !err));
  p_rollback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rollback_req && ckpt_valid) |=> (restore_valid && !ckpt_valid && !stall));
  p_restore_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> !restore_valid);
  p_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((commit_req || rollback_req) && !ckpt_valid) |=> (err && !restore_valid));
  p_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_req || rollback_req) |=> !err);
  p_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((commit_req || rollback_req) && !stall) |=> !stall);
endmodule

bind regfile_ckpt regfile_ckpt_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .begin_req(begin_req), .commit_req(commit_req),
  .rollback_req(rollback_req), .stall(stall), .ckpt_done(ckpt_done),
  .ckpt_valid(ckpt_valid), .restore_valid(restore_valid), .err(err)
);

// File: tb/regfile_ckpt_tb_top.sv
`timescale 1ns/1ps
module regfile_ckpt_tb_top;
  localparam int NREG = 8;
  localparam int DW   = 16;
  localparam int PCW  = 16;
  localparam int AW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic wr_en = 0, begin_req = 0, commit_req = 0, rollback_req = 0;
  logic [PCW-1:0] pc_in = '0, restore_pc;
  logic stall, ckpt_done, ckpt_valid, restore_valid, err;

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] m  [NREG];
  logic [DW-1:0] sh [NREG];
  logic [PCW-1:0] shpc;

  always #10 clk = ~clk;

  regfile_ckpt #(.NREG(NREG), .DW(DW), .PCW(PCW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pc_in(pc_in),
    .begin_req(begin_req), .commit_req(commit_req), .rollback_req(rollback_req),
    .stall(stall), .ckpt_done(ckpt_done), .ckpt_valid(ckpt_valid),
    .restore_valid(restore_valid), .restore_pc(restore_pc), .err(err)
  );

  function automatic logic [DW-1:0] pat(int p, int a);
    return DW'(p * 16'h1357 + a * 16'h0101 + 3);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clr();
    wr_en = 0; begin_req = 0; commit_req = 0; rollback_req = 0;
  endtask

  task automatic write_all(int p);
    for (int a = 0; a < NREG; a++) begin
      wr_en = 1; wr_addr = AW'(a); wr_data = pat(p, a);
      tick();
      m[a] = pat(p, a);
    end
    wr_en = 0;
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < NREG; a++) begin
      rd_a_addr = AW'(a); rd_b_addr = AW'(NREG - 1 - a);
      #1;
      chk({tag, " port A"}, 32'(rd_a_data), 32'(m[a]));
      chk({tag, " port B"}, 32'(rd_b_data), 32'(m[NREG - 1 - a]));
    end
  endtask

  // mode 0: quiet copy, 1: writes every cycle (R3), 2: begin every cycle + commit (R7/R8)
  task automatic take_ckpt(logic [PCW-1:0] pc, int mode);
    int k;
    begin_req = 1; pc_in = pc;
    tick();
    begin_req = 0;
    shpc = pc;
    for (int a = 0; a < NREG; a++) sh[a] = m[a];
    chk("R2 stall after begin", 32'(stall), 1);
    k = 0;
    while (1) begin
      wr_en = (mode == 1); wr_addr = AW'(k); wr_data = ~pat(9, k);
      begin_req = (mode == 2);
      commit_req = (mode == 2 && k == 3);
      tick();
      k++;
      if (mode == 2 && k == 4) chk("R7 commit during copy flags err", 32'(err), 1);
      if (ckpt_done || k > NREG + 4) break;
    end
    chk("R2 done after NREG cycles", 32'(k), 32'(NREG));
    chk("R2 stall held in done cycle", 32'(stall), 1);
    chk("R2 valid with done", 32'(ckpt_valid), 1);
    commit_req = 0;
    tick();
    clr();
    chk("R2 stall released after done", 32'(stall), 0);
    chk("R2 done single pulse", 32'(ckpt_done), 0);
    check_all("R3 writes blocked during stall");
  endtask

  task automatic do_rollback(string tag);
    rollback_req = 1;
    tick();
    rollback_req = 0;
    chk({tag, " R6 restore_valid"}, 32'(restore_valid), 1);
    chk({tag, " R6 restore_pc"}, 32'(restore_pc), 32'(shpc));
    chk({tag, " R5 valid cleared"}, 32'(ckpt_valid), 0);
    for (int a = 0; a < NREG; a++) m[a] = sh[a];
    check_all({tag, " R5 restored"});
    tick();
    chk({tag, " R6 one-cycle pulse"}, 32'(restore_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < NREG; a++) m[a] = '0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R10 reset state
    chk("R10 stall", 32'(stall), 0);
    chk("R10 done", 32'(ckpt_done), 0);
    chk("R10 valid", 32'(ckpt_valid), 0);
    chk("R10 restore_valid", 32'(restore_valid), 0);
    chk("R10 err", 32'(err), 0);
    check_all("R10 regs zero");

    // R1 write/read sweep
    write_all(1);
    check_all("R1 readback");

    // R7 commit and rollback without checkpoint
    commit_req = 1; tick(); clr();
    chk("R7 err after commit", 32'(err), 1);
    chk("R7 valid stays low", 32'(ckpt_valid), 0);
    check_all("R7 regs unchanged");
    rollback_req = 1; tick(); clr();
    chk("R7 err after rollback", 32'(err), 1);
    chk("R7 no restore pulse", 32'(restore_valid), 0);
    check_all("R7 regs unchanged");
    tick();
    chk("R7 err is a pulse", 32'(err), 0);

    // R2/R3/R5/R6 checkpoint with blocked writes, then rollback
    take_ckpt(16'h1234, 1);
    write_all(2);
    check_all("R1 writes after release");
    do_rollback("rb1");
    rollback_req = 1; tick(); clr();
    chk("R7 second rollback errs", 32'(err), 1);
    check_all("R7 regs kept");

    // R4 commit keeps live registers
    take_ckpt(16'h2222, 0);
    write_all(3);
    commit_req = 1; tick(); clr();
    chk("R4 valid cleared", 32'(ckpt_valid), 0);
    chk("R4 no restore", 32'(restore_valid), 0);
    chk("R4 no err", 32'(err), 0);
    check_all("R4 regs kept");

    // R8 new checkpoint replaces a valid one
    take_ckpt(16'h3A3A, 0);
    write_all(4);
    take_ckpt(16'h4B4B, 0);
    write_all(5);
    do_rollback("R8 retake");

    // R8 begin while stalled ignored, R7 commit during copy
    take_ckpt(16'h5C5C, 2);
    chk("R7 checkpoint still completes", 32'(ckpt_valid), 1);
    for (int c = 0; c < NREG + 2; c++) begin
      chk("R8 no second copy stall", 32'(stall), 0);
      chk("R8 no second done", 32'(ckpt_done), 0);
      tick();
    end
    write_all(6);

    // R9 all requests plus a write in one cycle
    rollback_req = 1; commit_req = 1; begin_req = 1;
    wr_en = 1; wr_addr = 0; wr_data = 16'hBEEF;
    tick(); clr();
    chk("R9 rollback wins", 32'(restore_valid), 1);
    chk("R9 begin dropped", 32'(stall), 0);
    chk("R9 restore_pc", 32'(restore_pc), 32'(shpc));
    for (int a = 0; a < NREG; a++) m[a] = sh[a];
    check_all("R9 write dropped under rollback");

    // R9 commit beats begin
    take_ckpt(16'h6D6D, 0);
    write_all(7);
    commit_req = 1; begin_req = 1; tick(); clr();
    chk("R9 commit clears valid", 32'(ckpt_valid), 0);
    chk("R9 begin dropped with commit", 32'(stall), 0);
    chk("R9 no restore", 32'(restore_valid), 0);
    check_all("R9 regs kept after commit");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule